// File: doc/BRIEF.md
# Compute-Unit Translation Lookaside Buffer with Shootdown

This block is the private first-level address translation cache of one compute unit. Lookups arrive after the unit's memory requests have been coalesced, each carrying a virtual page number and a load/store flag. The block searches every entry at once. On a hit it returns the physical frame number and the permission bits one cycle later. On a miss it raises a walk request to a page walker shared by many units, tagged with this unit's identifier. It then accepts only the walk reply addressed to that identifier.

Only one miss may be outstanding. While it is open the block drops its ready and drives a stall output, which holds the issuing instruction as if it were waiting on memory. The reply is forwarded to the requester and installed into the victim slot, which a round-robin pointer chooses. A reply can instead report a page fault. In that case nothing is installed, and the requester retries the access once the fault has been resolved.

A shootdown port lets the host invalidate one page or flush the whole buffer. A shootdown that targets the page of an outstanding miss stops the reply from being installed, so a stale translation can never enter the buffer.

Top module: `cu_tlb`

## Requirements
- R1: After reset, every entry is invalid, `lk_ready` is 1, and `stall`, `rsp_valid` and `wreq_valid` are 0. The first lookup of any page misses.
- R2: An accepted lookup that hits gives `rsp_valid`=1 one cycle later, with the stored frame and permissions and `rsp_fault`=0 (unless R7 applies). No walk request is raised.
- R3: An accepted lookup that misses gives a one-cycle `wreq_valid` one cycle later, with `wreq_vpn` equal to the page and `wreq_src` equal to UNIT_ID. From that cycle on, `stall` is 1 and `lk_ready` is 0 until the matching reply is taken.
- R4: A walk reply whose `wrsp_dst` differs from UNIT_ID is ignored: no response is produced and the stall stays in force.
- R5: A matching, non-faulting reply produces `rsp_valid` one cycle later, carrying the reply's frame and permissions. In that same cycle `stall` drops. The page is installed, so a later lookup of it hits.
- R6: A reply with `wrsp_fault`=1 produces `rsp_valid` with `rsp_fault`=1 and a zero frame and permissions. Nothing is installed, so a retried lookup of that page raises a new walk request.
- R7: Permission bit 0 is read, bit 1 is write and bit 2 is execute. A store whose translation lacks bit 1 returns `rsp_fault`=1 with a zero frame. This applies to a store that hits and to a store that misses. A walked translation is still installed when the walker itself reported no fault.
- R8: A single-page shootdown (`sd_valid`=1, `sd_all`=0) invalidates only the entry holding `sd_vpn`. Other entries keep hitting.
- R9: A flush shootdown (`sd_valid`=1, `sd_all`=1) clears every valid bit in one cycle.
- R10: A shootdown of the page of an outstanding miss, arriving before or together with the reply, does not suppress the reply to the requester. The reply is not installed.
- R11: Installs fill slots in cyclic order starting at slot 0. Once all slots are full, the next install evicts the page installed earliest.
- R12: A shootdown in the same cycle as a lookup of the same page takes precedence, and the lookup is handled as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted when high |
| lk_vpn | input | VPN_W | Virtual page number of the lookup |
| lk_store | input | 1 | Lookup is for a store |
| rsp_valid | output | 1 | Translation response |
| rsp_fault | output | 1 | Response is a fault |
| rsp_pfn | output | PFN_W | Physical frame number, zero on fault |
| rsp_perm | output | PERM_W | Permission bits, zero on fault |
| stall | output | 1 | Requester hold while a miss is open |
| wreq_valid | output | 1 | Walk request pulse |
| wreq_vpn | output | VPN_W | Page to walk |
| wreq_src | output | ID_W | This unit's identifier |
| wrsp_valid | input | 1 | Walk reply on the shared return path |
| wrsp_dst | input | ID_W | Unit the reply is addressed to |
| wrsp_pfn | input | PFN_W | Walked frame number |
| wrsp_perm | input | PERM_W | Walked permission bits |
| wrsp_fault | input | 1 | Walk ended in a page fault |
| sd_valid | input | 1 | Shootdown message |
| sd_all | input | 1 | Shootdown flushes everything |
| sd_vpn | input | VPN_W | Page to shoot down |

## Verification
On every cycle, the assertions check the following: at most one entry matches a lookup, a flush leaves no valid bit, a faulting response carries no frame, a reply addressed to another unit leaves the stall in place, and a killed reply leaves the valid set untouched. Some behaviour only the bench scenarios can show, because it needs a history of installs and invalidations to be observed through later lookups. This covers round-robin eviction order, the survival of unrelated entries after a page shootdown, installs despite store faults, the retry after a walk fault, and the precedence of a same-cycle shootdown.

// File: rtl/cu_tlb.sv
module cu_tlb #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 36,
  parameter int PFN_W   = 40,
  parameter int PERM_W  = 3,
  parameter int ID_W    = 8,
  parameter int UNIT_ID = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_store,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [PERM_W-1:0] rsp_perm,
  output logic              stall,
  output logic              wreq_valid,
  output logic [VPN_W-1:0]  wreq_vpn,
  output logic [ID_W-1:0]   wreq_src,
  input  logic              wrsp_valid,
  input  logic [ID_W-1:0]   wrsp_dst,
  input  logic [PFN_W-1:0]  wrsp_pfn,
  input  logic [PERM_W-1:0] wrsp_perm,
  input  logic              wrsp_fault,
  input  logic              sd_valid,
  input  logic              sd_all,
  input  logic [VPN_W-1:0]  sd_vpn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int WR_BIT = 1;

  logic [ENTRIES-1:0] val, hit_vec, sd_vec, live_hit;
  logic [VPN_W-1:0]   tag    [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];
  logic [IDX_W-1:0]   rr;

  logic             busy, pend_store, pend_kill;
  logic [VPN_W-1:0] pend_vpn;
  logic [PFN_W-1:0] hpfn;
  logic [PERM_W-1:0] hperm;
  logic             hit, lk_fire, sd_pend, rsp_take, install;
  logic             hit_fault, walk_fault;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_match
      assign hit_vec[g] = val[g] && (tag[g] == lk_vpn);
      assign sd_vec[g]  = sd_valid && (sd_all || tag[g] == sd_vpn);
    end
  endgenerate

  assign live_hit = hit_vec & ~sd_vec;
  assign hit      = |live_hit;

  always_comb begin
    hpfn  = '0;
    hperm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (live_hit[i]) begin
        hpfn  = hpfn  | pfn_q[i];
        hperm = hperm | perm_q[i];
      end
    end
  end

  assign lk_ready   = !busy;
  assign stall      = busy;
  assign lk_fire    = lk_valid && !busy;
  assign sd_pend    = sd_valid && (sd_all || sd_vpn == (busy ? pend_vpn : lk_vpn));
  assign rsp_take   = busy && wrsp_valid && (wrsp_dst == ID_W'(UNIT_ID));
  assign install    = rsp_take && !wrsp_fault && !pend_kill && !sd_pend;
  assign hit_fault  = lk_store && !hperm[WR_BIT];
  assign walk_fault = wrsp_fault || (pend_store && !wrsp_perm[WR_BIT]);
  assign wreq_vpn   = pend_vpn;
  assign wreq_src   = ID_W'(UNIT_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
      rr  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (install && rr == IDX_W'(i)) val[i] <= 1'b1;
        else if (sd_vec[i])             val[i] <= 1'b0;
      end
      if (install) rr <= (rr == IDX_W'(ENTRIES-1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      tag[rr]    <= pend_vpn;
      pfn_q[rr]  <= wrsp_pfn;
      perm_q[rr] <= wrsp_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pend_vpn   <= '0;
      pend_store <= 1'b0;
      pend_kill  <= 1'b0;
      wreq_valid <= 1'b0;
    end else begin
      wreq_valid <= lk_fire && !hit;
      if (lk_fire && !hit) begin
        busy       <= 1'b1;
        pend_vpn   <= lk_vpn;
        pend_store <= lk_store;
        pend_kill  <= sd_pend;
      end else if (rsp_take) begin
        busy      <= 1'b0;
        pend_kill <= 1'b0;
      end else if (busy && sd_pend) begin
        pend_kill <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pfn   <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= (lk_fire && hit) || rsp_take;
      if (lk_fire && hit) begin
        rsp_fault <= hit_fault;
        rsp_pfn   <= hit_fault ? '0 : hpfn;
        rsp_perm  <= hit_fault ? '0 : hperm;
      end else if (rsp_take) begin
        rsp_fault <= walk_fault;
        rsp_pfn   <= walk_fault ? '0 : wrsp_pfn;
        rsp_perm  <= walk_fault ? '0 : wrsp_perm;
      end
    end
  end

  assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sd_valid && sd_all |=> val == '0);

  assert_walk_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wreq_valid) |-> $past(lk_valid) && !$past(busy) && stall);

  assert_fault_no_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pfn == '0 && rsp_perm == '0);

  assert_foreign_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wrsp_valid && wrsp_dst != ID_W'(UNIT_ID) |=> stall && !rsp_valid);

  assert_killed_not_installed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && (pend_kill || sd_pend) |=> rsp_valid && val == $past(val & ~sd_vec));
endmodule

// File: tb/sim_cu_tlb.sv
module sim_cu_tlb;
  localparam int UID = 5;
  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, lk_store = 0, lk_ready;
  logic [35:0] lk_vpn = '0;
  logic rsp_valid, rsp_fault, stall, wreq_valid;
  logic [39:0] rsp_pfn;
  logic [2:0] rsp_perm;
  logic [35:0] wreq_vpn;
  logic [7:0] wreq_src;
  logic wrsp_valid = 0, wrsp_fault = 0;
  logic [7:0] wrsp_dst = '0;
  logic [39:0] wrsp_pfn = '0;
  logic [2:0] wrsp_perm = '0;
  logic sd_valid = 0, sd_all = 0;
  logic [35:0] sd_vpn = '0;

  int checks = 0, errors = 0;
  logic [35:0] m_vpn [32];
  bit m_val [32];
  int m_rr = 0;

  always #4 clk = ~clk;

  cu_tlb #(.UNIT_ID(UID)) u0 (.*);

  function automatic logic [39:0] pfn_of(logic [35:0] v);
    return {4'hA, v ^ 36'h5_A5A5_A5A5};
  endfunction
  function automatic logic [2:0] perm_of(logic [35:0] v);
    return v[2:0];
  endfunction
  function automatic bit fault_of(logic [35:0] v);
    return v[5:3] == 3'b111;
  endfunction
  function automatic int m_find(logic [35:0] v);
    for (int i = 0; i < 32; i++) if (m_val[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic check(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic m_inval(bit all, logic [35:0] v);
    for (int i = 0; i < 32; i++) if (all || m_vpn[i] == v) m_val[i] = 0;
  endtask

  task automatic shoot(bit all, logic [35:0] v);
    @(negedge clk); sd_valid = 1; sd_all = all; sd_vpn = v;
    @(negedge clk); sd_valid = 0; sd_all = 0;
    m_inval(all, v);
  endtask

  task automatic reply(logic [35:0] v, bit st, bit kill, bit foreign, bit killed_in, string r);
    bit killed = killed_in;
    bit f;
    if (foreign) begin
      @(negedge clk); wrsp_valid = 1; wrsp_dst = 8'(UID + 1);
      wrsp_pfn = 40'h1234; wrsp_perm = 3'b111; wrsp_fault = 0;
      @(negedge clk); wrsp_valid = 0;
      check({r, " R4 rsp"}, rsp_valid, 0);
      check({r, " R4 stall"}, stall, 1);
    end
    if (kill) begin
      shoot(0, v);
      killed = 1;
    end
    @(negedge clk); wrsp_valid = 1; wrsp_dst = 8'(UID);
    wrsp_pfn = pfn_of(v); wrsp_perm = perm_of(v); wrsp_fault = fault_of(v);
    @(negedge clk); wrsp_valid = 0;
    f = fault_of(v) || (st && !perm_of(v)[1]);
    check({r, " rsp_valid"}, rsp_valid, 1);
    check({r, " rsp_fault"}, rsp_fault, f);
    check({r, " rsp_pfn"}, rsp_pfn, f ? 40'h0 : pfn_of(v));
    check({r, " rsp_perm"}, rsp_perm, f ? 3'h0 : perm_of(v));
    check({r, " stall drop"}, stall, 0);
    if (!fault_of(v) && !killed) begin
      m_vpn[m_rr] = v; m_val[m_rr] = 1; m_rr = (m_rr + 1) % 32;
    end
  endtask

  task automatic lookup(logic [35:0] v, bit st, string r, bit kill = 0, bit foreign = 0);
    int i;
    @(negedge clk);
    check({r, " ready"}, lk_ready, 1);
    lk_valid = 1; lk_vpn = v; lk_store = st;
    @(negedge clk); lk_valid = 0;
    i = m_find(v);
    if (i >= 0) begin
      bit f = st && !perm_of(v)[1];
      check({r, " hit rsp_valid"}, rsp_valid, 1);
      check({r, " hit fault"}, rsp_fault, f);
      check({r, " hit pfn"}, rsp_pfn, f ? 40'h0 : pfn_of(v));
      check({r, " hit no walk"}, wreq_valid, 0);
    end else begin
      check({r, " R3 wreq"}, wreq_valid, 1);
      check({r, " R3 wreq_vpn"}, wreq_vpn, v);
      check({r, " R3 src"}, wreq_src, UID);
      check({r, " R3 stall"}, stall, 1);
      check({r, " R3 ready"}, lk_ready, 0);
      reply(v, st, kill, foreign, 0, r);
    end
  endtask

  task automatic expect_miss(logic [35:0] v, string r);
    check(r, m_find(v) < 0, 1);
    lookup(v, 0, r);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int dummy;
    for (int i = 0; i < 32; i++) begin m_val[i] = 0; m_vpn[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready", lk_ready, 1);
    check("R1 stall", stall, 0);
    check("R1 rsp", rsp_valid, 0);
    check("R1 wreq", wreq_valid, 0);
    expect_miss(36'h0_0000_0007, "R1 first miss");
    lookup(36'h0_0000_0007, 0, "R2 hit");
    lookup(36'h0_0000_0007, 1, "R2 store hit");
    lookup(36'h0_0000_0046, 0, "R5 install", 0, 1);
    lookup(36'h0_0000_0046, 0, "R5 rehit");
    lookup(36'h0_0000_0038, 0, "R6 walk fault");
    expect_miss(36'h0_0000_0038, "R6 retry");
    lookup(36'h0_0000_0101, 1, "R7 store miss no write");
    lookup(36'h0_0000_0101, 0, "R7 load hit");
    lookup(36'h0_0000_0101, 1, "R7 store hit no write");
    lookup(36'h0_0000_0202, 0, "R8 setup");
    shoot(0, 36'h0_0000_0101);
    lookup(36'h0_0000_0202, 0, "R8 survivor hits");
    expect_miss(36'h0_0000_0101, "R8 victim misses");
    lookup(36'h0_0000_0303, 0, "R10 killed", 1, 0);
    expect_miss(36'h0_0000_0303, "R10 not installed");
    lookup(36'h0_0000_0077, 0, "R12 setup");
    @(negedge clk);
    lk_valid = 1; lk_vpn = 36'h0_0000_0077; lk_store = 0;
    sd_valid = 1; sd_all = 0; sd_vpn = 36'h0_0000_0077;
    @(negedge clk); lk_valid = 0; sd_valid = 0;
    m_inval(0, 36'h0_0000_0077);
    check("R12 miss on same-cycle shootdown", wreq_valid, 1);
    check("R12 no hit rsp", rsp_valid, 0);
    reply(36'h0_0000_0077, 0, 0, 0, 1, "R12 reply");
    shoot(1, '0);
    expect_miss(36'h0_0000_0046, "R9 flush");
    expect_miss(36'h0_0000_0202, "R9 flush second");
    shoot(1, '0);
    for (int k = 0; k <= 32; k++) lookup(36'h0_0000_1000 + 36'(k * 64), 0, "R11 fill");
    check("R11 oldest evicted", m_find(36'h0_0000_1000) < 0, 1);
    expect_miss(36'h0_0000_1000, "R11 oldest evicted");
    lookup(36'h0_0000_1000 + 36'(32 * 64), 0, "R11 newest hits");
    dummy = $urandom(32'd77);
    for (int n = 0; n < 600; n++) begin
      int r = $urandom % 16;
      logic [35:0] v = 36'h0_0000_4000 + 36'($urandom % 48);
      if (r < 11) lookup(v, 1'($urandom % 2), "R5 random", ($urandom % 8) == 0, ($urandom % 6) == 0);
      else if (r < 15) shoot(0, v);
      else shoot(1, '0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule